// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs a single access on an external memory bus as a short sequence of cycle states. A start state comes first. It is followed by a run of wait states and then by an end state. A configuration count sets how many wait states an access has at minimum. An active-low wait input from the external device can add more wait states, but only at the point where the last programmed wait state would hand over to the end state.

The CPU side has a simple handshake. A one-cycle request carries the address, the write data, the direction and an access-kind tag. An acknowledge pulse marks completion, and on reads the captured data is valid during that pulse.

The wait input is sampled on the falling clock edge into a register, and the rising-edge state logic uses that register. Three access kinds ignore the wait input completely:

- DMA 16-byte dual-address writes
- transfers from a device with a DMA acknowledge line to external memory
- cache write-backs

For these kinds the length of the cycle depends only on the programmed count.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset the chip select, start strobe, read strobe, write strobe and data output enable are all inactive (high for the active-low strobes, low for the enable), and `ack` is low.
- R2: An access accepted in cycle 0 (with `req_valid` high while idle) has its start state in cycle 1, then B wait states, then the end state. `ack` is high for exactly one cycle, the cycle after the end state. B is `cfg_tw_cnt`, except that a value of 0 is treated as 1.
- R3: `bus_bs_n` is low only in the start state. `bus_cs_n` is low from the start state through the end state. `bus_addr` holds the request address while `bus_cs_n` is low.
- R4: On reads, `bus_rd_n` is low across the wait and end states. On writes, `bus_we_n` is low across the wait states only, and `bus_doe` is high with `bus_dout` equal to the write data while `bus_cs_n` is low.
- R5: On reads, `rdata` equals the value of `bus_din` during the end state. It is valid while `ack` is high.
- R6: If `bus_wait_n` is sampled low in the last wait state, one more wait state is inserted. The same check repeats at the end of every inserted wait state. The end state follows the first wait state in which the sample is high.
- R7: A low level on `bus_wait_n` during the start state or the first wait state does not change the access length.
- R8: With `cfg_tw_cnt` of 0 or 1, `bus_wait_n` never lengthens an access.
- R9: `req_kind` encoding: 0 is an ordinary access, 1 is a DMA 16-byte dual-address write, 2 is a device-to-external transfer, and 3 is a cache write-back. For kinds 1 to 3, `bus_wait_n` is ignored.
- R10: With `cfg_wait_en` low, `bus_wait_n` is ignored for every access kind.
- R11: `bus_wait_n` is sampled on the falling edge of `clk`. A low level that is present at the falling edge inside the last wait state stretches the access, even if the level has returned high before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tw_cnt | input | 3 | Programmed wait-state count (0 means 1) |
| cfg_wait_en | input | 1 | Enables the external wait input |
| req_valid | input | 1 | One-cycle access request, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | Access kind tag (see R9) |
| req_addr | input | 26 | Access address |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data captured in the end state |
| bus_addr | output | 26 | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_bs_n | output | 1 | Start strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_dout | output | 32 | Write data to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 32 | Read data from the bus |
| bus_wait_n | input | 1 | External wait request, active low |

## Verification
The bench holds `bus_wait_n` low at chosen positions in an access and measures the cycle in which `ack` arrives. A design that checks the wait input in every wait state would stretch accesses when the wait is low only in the start or first wait state. A design that leaves out the suppression for the three special kinds, or for the disabled case, would produce longer cycles for those accesses. One case raises the wait input again after the falling edge but before the rising edge, which separates falling-edge sampling from rising-edge sampling. Counts of 0 and 1 are run with wait held low to catch a design that has no lower bound on the wait stage. Strobe windows and the captured read data are compared cycle by cycle, which exposes a design where they are misaligned by one cycle.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2,
        ST_END   = 2'd3
    } cyc_state_e;

    typedef enum logic [1:0] {
        KIND_NORMAL   = 2'd0,
        KIND_DMA16_WR = 2'd1,
        KIND_DEV_XFER = 2'd2,
        KIND_CACHE_WB = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/xbus_wait_sample.sv
`timescale 1ns/1ps
module xbus_wait_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n_in,
    output logic wait_smp
);
    // Falling-edge capture; the rising-edge logic reads the held value.
    logic smp_d;
    logic smp_q;

    always_comb begin
        smp_d = ~wait_n_in;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign wait_smp = smp_q;
endmodule

// File: rtl/xbus_wait_gate.sv
`timescale 1ns/1ps
module xbus_wait_gate
    import xbus_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             wait_en,
    input  acc_kind_e        kind,
    input  logic [CNT_W-1:0] base_cnt,
    output logic             honour
);
    localparam logic [CNT_W-1:0] MIN_STRETCH = CNT_W'(2);

    logic kind_ok;
    logic cnt_ok;

    always_comb begin
        kind_ok = (kind == KIND_NORMAL);
        cnt_ok  = (base_cnt >= MIN_STRETCH);
        honour  = wait_en && kind_ok && cnt_ok;
    end
endmodule

// File: rtl/xbus_cycle_fsm.sv
`timescale 1ns/1ps
module xbus_cycle_fsm
    import xbus_pkg::*;
#(
    parameter int AW    = 26,
    parameter int DW    = 32,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_tw_cnt,
    input  logic             req_valid,
    input  logic             req_write,
    input  acc_kind_e        req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW-1:0]    bus_din,
    input  logic             stretch,
    output cyc_state_e       state,
    output logic             last_tw,
    output acc_kind_e        kind,
    output logic [CNT_W-1:0] base_cnt,
    output logic             is_write,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             ack
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        cyc_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] base;
        acc_kind_e        kind;
        logic             wr;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
        logic             ack;
    } fsm_regs_t;

    fsm_regs_t r_d;
    fsm_regs_t r_q;
    logic      at_last;

    always_comb begin
        at_last = (r_q.st == ST_WAIT) && (r_q.cnt >= r_q.base);
        r_d     = r_q;
        r_d.ack = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_START;
                    r_d.base  = (cfg_tw_cnt == '0) ? ONE : cfg_tw_cnt;
                    r_d.kind  = req_kind;
                    r_d.wr    = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.cnt   = '0;
                end
            end
            ST_START: begin
                r_d.st  = ST_WAIT;
                r_d.cnt = ONE;
            end
            ST_WAIT: begin
                if (!at_last) begin
                    r_d.cnt = r_q.cnt + ONE;
                end else if (!stretch) begin
                    r_d.st = ST_END;
                end
            end
            ST_END: begin
                r_d.st  = ST_IDLE;
                r_d.ack = 1'b1;
                if (!r_q.wr) begin
                    r_d.rdata = bus_din;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, base: ONE, kind: KIND_NORMAL,
                     wr: 1'b0, addr: '0, wdata: '0, rdata: '0, ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.st;
    assign last_tw  = at_last;
    assign kind     = r_q.kind;
    assign base_cnt = r_q.base;
    assign is_write = r_q.wr;
    assign addr     = r_q.addr;
    assign wdata    = r_q.wdata;
    assign rdata    = r_q.rdata;
    assign ack      = r_q.ack;
endmodule

// File: rtl/xbus_wait_ctrl.sv
`timescale 1ns/1ps
module xbus_wait_ctrl
    import xbus_pkg::*;
#(
    parameter int AW    = 26,
    parameter int DW    = 32,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_tw_cnt,
    input  logic             cfg_wait_en,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             ack,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_cs_n,
    output logic             bus_bs_n,
    output logic             bus_rd_n,
    output logic             bus_we_n,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_doe,
    input  logic [DW-1:0]    bus_din,
    input  logic             bus_wait_n
);
    cyc_state_e       cyc_state;
    acc_kind_e        acc_kind;
    logic             last_tw;
    logic [CNT_W-1:0] acc_base;
    logic             acc_wr;
    logic [DW-1:0]    acc_wdata;
    logic             wait_smp;
    logic             honour;
    logic             stretch;

    xbus_wait_sample u_sample (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_n_in (bus_wait_n),
        .wait_smp  (wait_smp)
    );

    xbus_wait_gate #(.CNT_W(CNT_W)) u_gate (
        .wait_en  (cfg_wait_en),
        .kind     (acc_kind),
        .base_cnt (acc_base),
        .honour   (honour)
    );

    assign stretch = honour && wait_smp;

    xbus_cycle_fsm #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_tw_cnt (cfg_tw_cnt),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_kind   (acc_kind_e'(req_kind)),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bus_din    (bus_din),
        .stretch    (stretch),
        .state      (cyc_state),
        .last_tw    (last_tw),
        .kind       (acc_kind),
        .base_cnt   (acc_base),
        .is_write   (acc_wr),
        .addr       (bus_addr),
        .wdata      (acc_wdata),
        .rdata      (rdata),
        .ack        (ack)
    );

    logic active;
    always_comb begin
        active   = (cyc_state != ST_IDLE);
        bus_cs_n = !active;
        bus_bs_n = !(cyc_state == ST_START);
        bus_rd_n = !(!acc_wr && (cyc_state == ST_WAIT || cyc_state == ST_END));
        bus_we_n = !(acc_wr && cyc_state == ST_WAIT);
        bus_doe  = acc_wr && active;
        bus_dout = acc_wdata;
    end
endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
`timescale 1ns/1ps
module xbus_wait_ctrl_chk
    import xbus_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             bus_cs_n,
    input logic             bus_bs_n,
    input logic             bus_rd_n,
    input logic             bus_we_n,
    input logic             cfg_wait_en,
    input cyc_state_e       cyc_state,
    input logic             last_tw,
    input acc_kind_e        acc_kind,
    input logic [CNT_W-1:0] acc_base,
    input logic             wait_smp
);
    AST_BS_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_bs_n |-> !bus_cs_n); // R3
    AST_BS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_bs_n |=> bus_bs_n); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_we_n)); // R4
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R2
    AST_ACK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> bus_cs_n); // R2
    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (last_tw && cfg_wait_en && acc_kind == KIND_NORMAL && acc_base >= CNT_W'(2) && wait_smp)
        |=> cyc_state == ST_WAIT); // R6
    AST_SMALL_CNT_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (last_tw && acc_base < CNT_W'(2)) |=> cyc_state == ST_END); // R8
    AST_KIND_IGNORES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (last_tw && acc_kind != KIND_NORMAL) |=> cyc_state == ST_END); // R9
    AST_DISABLED_IGNORES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (last_tw && !cfg_wait_en) |=> cyc_state == ST_END); // R10
endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .bus_cs_n    (bus_cs_n),
    .bus_bs_n    (bus_bs_n),
    .bus_rd_n    (bus_rd_n),
    .bus_we_n    (bus_we_n),
    .cfg_wait_en (cfg_wait_en),
    .cyc_state   (cyc_state),
    .last_tw     (last_tw),
    .acc_kind    (acc_kind),
    .acc_base    (acc_base),
    .wait_smp    (wait_smp)
);

// File: tb/xbus_wait_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_wait_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_tw_cnt = 3'd0;
    logic        cfg_wait_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [25:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic [25:0] bus_addr;
    logic        bus_cs_n, bus_bs_n, bus_rd_n, bus_we_n, bus_doe;
    logic [31:0] bus_dout;
    logic [31:0] bus_din = '0;
    logic        bus_wait_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xbus_wait_ctrl u_xbus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_tw_cnt(cfg_tw_cnt), .cfg_wait_en(cfg_wait_en),
        .req_valid(req_valid), .req_write(req_write), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_bs_n(bus_bs_n),
        .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_wait_n(bus_wait_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access; the wait input is low for cycles ws .. ws+wl-1 (cycle 0 = request cycle).
    task automatic do_access(input bit wr, input logic [1:0] kind, input int n,
                             input bit en, input int ws, input int wl,
                             input bit glitch, input string lreq);
        int base;
        bit hon;
        int extra;
        int exp_ack;
        int got_ack;
        int e_bs, e_cs, e_strb;
        logic [25:0] a;
        logic [31:0] wd;
        logic [31:0] din_end;
        base = (n < 1) ? 1 : n;
        hon = en && (kind == 2'd0) && (base >= 2);
        extra = 0;
        if (hon) begin
            while ((base + 1 + extra) >= ws && (base + 1 + extra) < ws + wl) extra++;
        end
        exp_ack = 3 + base + extra;
        got_ack = -1;
        e_bs = 0; e_cs = 0; e_strb = 0;
        a = 26'h0100000 + 26'(n * 16) + 26'(kind);
        wd = 32'hC0DE0000 + 32'(n * 256) + 32'(ws);
        din_end = '0;
        cfg_tw_cnt = n[2:0];
        cfg_wait_en = en;
        for (int k = 0; k < 64; k++) begin
            @(posedge clk);
            #1;
            req_valid = (k == 0);
            req_write = wr;
            req_kind = kind;
            req_addr = a;
            req_wdata = wd;
            bus_wait_n = !(k >= ws && k < ws + wl);
            bus_din = 32'h5A000000 + 32'(k * 7);
            #2;
            if (bus_bs_n != !(k == 1)) e_bs++;
            if (bus_cs_n != !(k >= 1 && k <= exp_ack - 1)) e_cs++;
            if (!bus_cs_n && bus_addr != a) e_cs++;
            if (bus_rd_n != !(!wr && k >= 2 && k <= exp_ack - 1)) e_strb++;
            if (bus_we_n != !(wr && k >= 2 && k <= exp_ack - 2)) e_strb++;
            if (bus_doe != (wr && k >= 1 && k <= exp_ack - 1)) e_strb++;
            if (wr && !bus_cs_n && bus_dout != wd) e_strb++;
            if (k == exp_ack - 1) din_end = bus_din;
            if (ack) got_ack = k;
            #2;
            if (glitch) bus_wait_n = 1'b1;
            if (got_ack >= 0) break;
        end
        req_valid = 1'b0;
        bus_wait_n = 1'b1;
        chk(got_ack == exp_ack, lreq, "ack cycle", got_ack, exp_ack);
        chk(e_bs == 0, "R3", "start strobe mismatches", e_bs, 0);
        chk(e_cs == 0, "R3", "select/address mismatches", e_cs, 0);
        chk(e_strb == 0, "R4", "strobe/data mismatches", e_strb, 0);
        if (!wr) chk(rdata == din_end, "R5", "read data", rdata, din_end);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        chk(bus_cs_n && bus_bs_n && bus_rd_n && bus_we_n && !bus_doe, "R1",
            "idle strobes", {bus_cs_n, bus_bs_n, bus_rd_n, bus_we_n, bus_doe}, 5'b11110);
        chk(ack == 1'b0, "R1", "ack in reset", ack, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_basic;
        do_access(1'b0, 2'd0, 3, 1'b1, 99, 0, 1'b0, "R2");
        do_access(1'b1, 2'd0, 4, 1'b1, 99, 0, 1'b0, "R2");
        do_access(1'b0, 2'd0, 7, 1'b0, 99, 0, 1'b0, "R2");
    endtask

    task automatic t_stretch;
        do_access(1'b0, 2'd0, 3, 1'b1, 4, 3, 1'b0, "R6");
        do_access(1'b1, 2'd0, 2, 1'b1, 2, 2, 1'b0, "R6");
    endtask

    task automatic t_early_wait;
        do_access(1'b0, 2'd0, 3, 1'b1, 1, 2, 1'b0, "R7");
    endtask

    task automatic t_small_count;
        do_access(1'b0, 2'd0, 0, 1'b1, 1, 10, 1'b0, "R8");
        do_access(1'b1, 2'd0, 1, 1'b1, 1, 10, 1'b0, "R8");
    endtask

    task automatic t_kinds;
        do_access(1'b1, 2'd1, 3, 1'b1, 1, 10, 1'b0, "R9");
        do_access(1'b1, 2'd2, 3, 1'b1, 1, 10, 1'b0, "R9");
        do_access(1'b1, 2'd3, 3, 1'b1, 1, 10, 1'b0, "R9");
    endtask

    task automatic t_disabled;
        do_access(1'b0, 2'd0, 3, 1'b0, 1, 10, 1'b0, "R10");
    endtask

    task automatic t_falling_edge;
        do_access(1'b0, 2'd0, 3, 1'b1, 4, 1, 1'b1, "R11");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_stretch();
        t_early_wait();
        t_small_count();
        t_kinds();
        t_disabled();
        t_falling_edge();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule